// File: doc/BRIEF.md
# Coherence Directory with Designated Forwarder and Dirty-Shared Owner

This block keeps, for a small set of tracked lines, the coherence state of every core's copy: Invalid, Shared, Exclusive, Modified, Owned or Forward. Cores send it three kinds of request: a shared read, an exclusive read (which also serves as a write upgrade), and an eviction that may carry a dirty flag. In reply the block issues snoop commands to the cores, strobes reads and writes to memory, and returns one grant per accepted request that names the state the requester now holds.

Each shared read is answered by exactly one supplier. If a dirty owner exists it supplies the data. Otherwise the sole Exclusive or Modified holder supplies it, or else the single Forward holder. The newest clean reader inherits the Forward role, so older sharers never answer. Modified data that other cores read stays dirty in an Owned copy. That ownership can move to a sharer at eviction time without any memory write. Only a request that must wait on memory or on invalidate acknowledgements holds a line busy. While it waits, requests to other lines that finish at once are still accepted.

Top module: `dir_ctrl`

## Requirements
- R1: After reset every line is Invalid in every core, `req_ready` is high, and `gnt_valid`, `snp_valid`, `mem_rd_valid` and `mem_wr_valid` are low.
- R2: A shared read of a line that no core holds raises `mem_rd_valid` with `mem_line` for one cycle, in the cycle after acceptance. After `mem_rd_done` it grants Exclusive (state code 2). If Shared copies of the line exist elsewhere, the grant is Forward (state code 5) instead.
- R3: A shared read of a line that has an Exclusive or Forward holder sends one snoop with command forward (code 0). `snp_mask` is one-hot on that holder and `snp_dest` names the requester. The requester is granted Forward, and the old holder drops to Shared and is not asked again.
- R4: A clean eviction by the Forward holder removes the Forward mark and promotes no Shared copy. The next shared read of that line goes to memory.
- R5: A shared read of a Modified line sends a forward snoop to the modifier, which becomes the Owned holder. The requester is granted Shared (code 1). Later shared reads are served by the owner and also receive Shared.
- R6: Evicting an Owned line that still has sharers sends a transfer-ownership snoop (code 2) to the lowest-numbered sharer, with no memory write. That core then supplies later shared reads.
- R7: A memory write strobe with the line comes with the eviction of a Modified copy, of an Owned copy without sharers, or of an Exclusive copy marked dirty. A clean eviction of any other copy issues no memory write.
- R8: An exclusive read with other holders sends an invalidate snoop (code 1) whose mask covers every other holder and excludes the requester. It grants Modified (code 3) only after every targeted core has acknowledged on `inv_ack`. An owner upgrading its line uses the same path.
- R9: An exclusive read by a core that holds nothing, of a line no other core holds, reads memory and grants Modified after `mem_rd_done`.
- R10: While a request waits on memory or acknowledgements, `req_ready` is low for any request to the same line. A request to another line that completes at once is accepted.
- R11: Every accepted request yields exactly one grant, in the cycle after it completes. An eviction grants Invalid (code 0). A read by a core whose current state already satisfies it grants that state at once, with no snoop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_core | input | CW | Requesting core |
| req_line | input | LW | Tracked line index |
| req_op | input | 2 | 0 shared read, 1 exclusive read/upgrade, 2 eviction |
| req_dirty | input | 1 | Eviction carries dirty data |
| snp_valid | output | 1 | Snoop command strobe |
| snp_cmd | output | 2 | 0 forward, 1 invalidate, 2 transfer ownership |
| snp_mask | output | NCORES | Cores that receive the snoop |
| snp_dest | output | CW | Requester the snoop serves |
| snp_line | output | LW | Line of the snoop |
| inv_ack | input | NCORES | Per-core invalidate acknowledgement |
| mem_rd_valid | output | 1 | Memory read strobe |
| mem_wr_valid | output | 1 | Memory write-back strobe |
| mem_line | output | LW | Line of the memory command |
| mem_rd_done | input | 1 | Memory read finished |
| gnt_valid | output | 1 | Grant strobe |
| gnt_core | output | CW | Granted core |
| gnt_line | output | LW | Granted line |
| gnt_state | output | 3 | State now held by the granted core |

## Verification
The bench walks one line through every state transition in turn: first fill from memory, Exclusive to Forward, Forward hand-over, Forward lost on eviction, invalidate fan-out, then Modified to Owned, ownership transfer and owner upgrade. A design that woke a Shared copy to supply data would send a forward snoop where a memory read is due. A design that granted Modified before the last acknowledgement would produce a grant too early. One that wrote back on an ownership transfer would raise a memory write that the bench flags. A second line holds a memory read open while the bench offers a same-line request, which must stall, and an other-line eviction, which must pass. This exposes a busy check that is either too broad or too narrow.

// File: rtl/dir_pkg.sv
package dir_pkg;
    typedef enum logic [2:0] {
        ST_I = 3'd0,
        ST_S = 3'd1,
        ST_E = 3'd2,
        ST_M = 3'd3,
        ST_O = 3'd4,
        ST_F = 3'd5
    } cstate_e;

    typedef enum logic [1:0] {
        OP_RDS = 2'd0,
        OP_RDX = 2'd1,
        OP_EVC = 2'd2
    } op_e;

    typedef enum logic [1:0] {
        SN_FWD  = 2'd0,
        SN_INV  = 2'd1,
        SN_XFER = 2'd2
    } snp_e;

    typedef enum logic [1:0] {
        PW_NONE = 2'd0,
        PW_MEM  = 2'd1,
        PW_ACK  = 2'd2
    } pwait_e;
endpackage

// File: rtl/dir_pick_low.sv
module dir_pick_low #(
    parameter int N  = 4,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic [N-1:0]  gnt,
    output logic [IW-1:0] idx,
    output logic          any
);
    // lowest set bit wins
    always_comb begin
        gnt = '0;
        idx = '0;
        any = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                gnt    = '0;
                gnt[i] = 1'b1;
                idx    = IW'(i);
                any    = 1'b1;
            end
        end
    end
endmodule

// File: rtl/dir_row_scan.sv
module dir_row_scan
    import dir_pkg::*;
#(
    parameter int NC = 4,
    parameter int CW = (NC > 1) ? $clog2(NC) : 1
) (
    input  cstate_e [NC-1:0] row,
    output logic [NC-1:0]    valid_m,
    output logic [NC-1:0]    shr_m,
    output logic [NC-1:0]    own_m,
    output logic [NC-1:0]    mod_m,
    output logic [NC-1:0]    sup_m,
    output logic [CW-1:0]    sup_idx,
    output logic             sup_any,
    output logic [NC-1:0]    shr_low_m,
    output logic [CW-1:0]    shr_low_idx,
    output logic             shr_any
);
    logic [NC-1:0] exc_m;
    logic [NC-1:0] fwd_m;
    logic [NC-1:0] pri_m;

    for (genvar c = 0; c < NC; c++) begin : g_core
        assign valid_m[c] = (row[c] != ST_I);
        assign shr_m[c]   = (row[c] == ST_S);
        assign own_m[c]   = (row[c] == ST_O);
        assign mod_m[c]   = (row[c] == ST_M);
        assign exc_m[c]   = (row[c] == ST_E);
        assign fwd_m[c]   = (row[c] == ST_F);
    end

    // supplier priority: dirty owner, sole modifier, sole exclusive, forwarder
    always_comb begin
        if (|own_m)      pri_m = own_m;
        else if (|mod_m) pri_m = mod_m;
        else if (|exc_m) pri_m = exc_m;
        else             pri_m = fwd_m;
    end

    dir_pick_low #(.N(NC), .IW(CW)) u_sup (
        .req (pri_m),
        .gnt (sup_m),
        .idx (sup_idx),
        .any (sup_any)
    );

    dir_pick_low #(.N(NC), .IW(CW)) u_shr (
        .req (shr_m),
        .gnt (shr_low_m),
        .idx (shr_low_idx),
        .any (shr_any)
    );
endmodule

// File: rtl/dir_ctrl.sv
module dir_ctrl
    import dir_pkg::*;
#(
    parameter int NCORES = 4,
    parameter int NLINES = 4,
    parameter int CW     = (NCORES > 1) ? $clog2(NCORES) : 1,
    parameter int LW     = (NLINES > 1) ? $clog2(NLINES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [CW-1:0]     req_core,
    input  logic [LW-1:0]     req_line,
    input  logic [1:0]        req_op,
    input  logic              req_dirty,
    output logic              snp_valid,
    output logic [1:0]        snp_cmd,
    output logic [NCORES-1:0] snp_mask,
    output logic [CW-1:0]     snp_dest,
    output logic [LW-1:0]     snp_line,
    input  logic [NCORES-1:0] inv_ack,
    output logic              mem_rd_valid,
    output logic              mem_wr_valid,
    output logic [LW-1:0]     mem_line,
    input  logic              mem_rd_done,
    output logic              gnt_valid,
    output logic [CW-1:0]     gnt_core,
    output logic [LW-1:0]     gnt_line,
    output logic [2:0]        gnt_state
);
    localparam int DIRW = NLINES * NCORES * 3;

    typedef struct packed {
        cstate_e [NLINES-1:0][NCORES-1:0] dir;
        pwait_e                           pw;
        logic [LW-1:0]                    p_line;
        logic [CW-1:0]                    p_core;
        op_e                              p_op;
        logic [NCORES-1:0]                p_left;
        logic                             gnt_v;
        logic [CW-1:0]                    gnt_core;
        logic [LW-1:0]                    gnt_line;
        cstate_e                          gnt_st;
        logic                             snp_v;
        snp_e                             snp_cmd;
        logic [NCORES-1:0]                snp_mask;
        logic [CW-1:0]                    snp_dest;
        logic [LW-1:0]                    snp_line;
        logic                             mrd_v;
        logic                             mwr_v;
        logic [LW-1:0]                    m_line;
    } st_t;

    st_t q, d;

    // scan of the requested line
    cstate_e [NCORES-1:0] r_row;
    logic [NCORES-1:0]    r_valid, r_shr, r_own, r_mod, r_sup, r_shr_low;
    logic [CW-1:0]        r_sup_idx, r_shr_idx;
    logic                 r_sup_any, r_shr_any;

    // scan of the pending line
    cstate_e [NCORES-1:0] p_row;
    logic [NCORES-1:0]    p_valid, p_shr, p_own, p_mod, p_sup, p_shr_low;
    logic [CW-1:0]        p_sup_idx, p_shr_idx;
    logic                 p_sup_any, p_shr_any;

    assign r_row = q.dir[req_line];
    assign p_row = q.dir[q.p_line];

    dir_row_scan #(.NC(NCORES), .CW(CW)) u_req_scan (
        .row         (r_row),
        .valid_m     (r_valid),
        .shr_m       (r_shr),
        .own_m       (r_own),
        .mod_m       (r_mod),
        .sup_m       (r_sup),
        .sup_idx     (r_sup_idx),
        .sup_any     (r_sup_any),
        .shr_low_m   (r_shr_low),
        .shr_low_idx (r_shr_idx),
        .shr_any     (r_shr_any)
    );

    dir_row_scan #(.NC(NCORES), .CW(CW)) u_pend_scan (
        .row         (p_row),
        .valid_m     (p_valid),
        .shr_m       (p_shr),
        .own_m       (p_own),
        .mod_m       (p_mod),
        .sup_m       (p_sup),
        .sup_idx     (p_sup_idx),
        .sup_any     (p_sup_any),
        .shr_low_m   (p_shr_low),
        .shr_low_idx (p_shr_idx),
        .shr_any     (p_shr_any)
    );

    logic [NCORES-1:0] req_bit, pend_bit, others;
    cstate_e           own_st, fill_st;
    op_e               op;
    logic              done_evt, needs_wait, acc;

    assign req_bit  = NCORES'(1) << req_core;
    assign pend_bit = NCORES'(1) << q.p_core;
    assign others   = r_valid & ~req_bit;
    assign own_st   = r_row[req_core];
    assign op       = op_e'(req_op);

    always_comb begin
        d       = q;
        d.gnt_v = 1'b0;
        d.snp_v = 1'b0;
        d.mrd_v = 1'b0;
        d.mwr_v = 1'b0;
        fill_st = ST_E;

        // completion of the outstanding transaction
        done_evt = 1'b0;
        case (q.pw)
            PW_MEM: done_evt = mem_rd_done;
            PW_ACK: begin
                d.p_left = q.p_left & ~inv_ack;
                done_evt = (d.p_left == '0);
            end
            default: done_evt = 1'b0;
        endcase

        if (done_evt) begin
            d.pw       = PW_NONE;
            d.gnt_v    = 1'b1;
            d.gnt_core = q.p_core;
            d.gnt_line = q.p_line;
            if (q.p_op == OP_RDS) begin
                fill_st = ((p_valid & ~pend_bit) != '0) ? ST_F : ST_E;
                d.dir[q.p_line][q.p_core] = fill_st;
                d.gnt_st = fill_st;
            end else begin
                for (int c = 0; c < NCORES; c++) begin
                    d.dir[q.p_line][c] = ST_I;
                end
                d.dir[q.p_line][q.p_core] = ST_M;
                d.gnt_st = ST_M;
            end
        end

        // does the incoming request need to wait on memory or acks
        case (op)
            OP_RDS:  needs_wait = (own_st == ST_I) && !r_sup_any;
            OP_RDX:  needs_wait = (others != '0) || (own_st == ST_I);
            default: needs_wait = 1'b0;
        endcase

        req_ready = !done_evt &&
                    !((q.pw != PW_NONE) && ((req_line == q.p_line) || needs_wait));
        acc = req_valid && req_ready;

        if (acc) begin
            d.gnt_core = req_core;
            d.gnt_line = req_line;
            d.snp_line = req_line;
            d.snp_dest = req_core;
            d.m_line   = req_line;
            case (op)
                OP_RDS: begin
                    if (own_st != ST_I) begin
                        d.gnt_v  = 1'b1;
                        d.gnt_st = own_st;
                    end else if (r_sup_any) begin
                        d.snp_v    = 1'b1;
                        d.snp_cmd  = SN_FWD;
                        d.snp_mask = r_sup;
                        d.gnt_v    = 1'b1;
                        if (r_own != '0) begin
                            d.gnt_st = ST_S;
                            d.dir[req_line][req_core] = ST_S;
                        end else if (r_mod != '0) begin
                            d.dir[req_line][r_sup_idx] = ST_O;
                            d.dir[req_line][req_core]  = ST_S;
                            d.gnt_st = ST_S;
                        end else begin
                            d.dir[req_line][r_sup_idx] = ST_S;
                            d.dir[req_line][req_core]  = ST_F;
                            d.gnt_st = ST_F;
                        end
                    end else begin
                        d.mrd_v  = 1'b1;
                        d.pw     = PW_MEM;
                        d.p_line = req_line;
                        d.p_core = req_core;
                        d.p_op   = OP_RDS;
                    end
                end
                OP_RDX: begin
                    if (others != '0) begin
                        d.snp_v    = 1'b1;
                        d.snp_cmd  = SN_INV;
                        d.snp_mask = others;
                        d.pw       = PW_ACK;
                        d.p_left   = others;
                        d.p_line   = req_line;
                        d.p_core   = req_core;
                        d.p_op     = OP_RDX;
                    end else if (own_st == ST_I) begin
                        d.mrd_v  = 1'b1;
                        d.pw     = PW_MEM;
                        d.p_line = req_line;
                        d.p_core = req_core;
                        d.p_op   = OP_RDX;
                    end else begin
                        d.dir[req_line][req_core] = ST_M;
                        d.gnt_v  = 1'b1;
                        d.gnt_st = ST_M;
                    end
                end
                default: begin
                    d.dir[req_line][req_core] = ST_I;
                    d.gnt_v  = 1'b1;
                    d.gnt_st = ST_I;
                    if (own_st == ST_M || (own_st == ST_E && req_dirty)) begin
                        d.mwr_v = 1'b1;
                    end else if (own_st == ST_O) begin
                        if (r_shr_any) begin
                            d.snp_v    = 1'b1;
                            d.snp_cmd  = SN_XFER;
                            d.snp_mask = r_shr_low;
                            d.dir[req_line][r_shr_idx] = ST_O;
                        end else begin
                            d.mwr_v = 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q          <= '0;
            q.pw       <= PW_NONE;
            q.snp_cmd  <= SN_FWD;
            q.p_op     <= OP_RDS;
            q.gnt_st   <= ST_I;
        end else begin
            q <= d;
        end
    end

    // flattened views for the bound checker
    logic [DIRW-1:0] dir_flat;
    logic            pend_busy;
    logic [LW-1:0]   pend_line;
    assign dir_flat  = q.dir;
    assign pend_busy = (q.pw != PW_NONE);
    assign pend_line = q.p_line;

    assign snp_valid    = q.snp_v;
    assign snp_cmd      = q.snp_cmd;
    assign snp_mask     = q.snp_mask;
    assign snp_dest     = q.snp_dest;
    assign snp_line     = q.snp_line;
    assign mem_rd_valid = q.mrd_v;
    assign mem_wr_valid = q.mwr_v;
    assign mem_line     = q.m_line;
    assign gnt_valid    = q.gnt_v;
    assign gnt_core     = q.gnt_core;
    assign gnt_line     = q.gnt_line;
    assign gnt_state    = q.gnt_st;
endmodule

// File: rtl/dir_ctrl_chk.sv
module dir_ctrl_chk #(
    parameter int NCORES = 4,
    parameter int NLINES = 4,
    parameter int CW     = 2,
    parameter int LW     = 2
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       req_valid,
    input logic                       req_ready,
    input logic [LW-1:0]              req_line,
    input logic                       snp_valid,
    input logic [1:0]                 snp_cmd,
    input logic [NCORES-1:0]          snp_mask,
    input logic [CW-1:0]              snp_dest,
    input logic                       mem_rd_valid,
    input logic                       mem_wr_valid,
    input logic                       gnt_valid,
    input logic [2:0]                 gnt_state,
    input logic [NLINES*NCORES*3-1:0] dir_flat,
    input logic                       pend_busy,
    input logic [LW-1:0]              pend_line
);
    // R3: a forward snoop goes to exactly one supplier
    a_r3_single_supplier: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && snp_cmd == 2'd0) |-> $onehot(snp_mask));

    // R8: invalidate fans out to others only, never the requester
    a_r8_inv_skips_requester: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && snp_cmd == 2'd1) |-> (snp_mask != '0 && !snp_mask[snp_dest]));

    // R6: ownership transfer replaces a write-back
    a_r6_xfer_no_writeback: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && snp_cmd == 2'd2) |-> !mem_wr_valid);

    // R2: a memory read leaves a transaction outstanding
    a_r2_read_holds_line: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid |-> pend_busy);

    // R10: a same-line request is stalled while busy
    a_r10_same_line_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_busy && req_valid && req_line == pend_line) |-> !req_ready);

    // R11: grant codes stay within the six defined states
    a_r11_grant_code: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid |-> (gnt_state <= 3'd5));

    for (genvar l = 0; l < NLINES; l++) begin : g_line
        logic [NCORES-1:0] fwd_m, own_m;
        for (genvar c = 0; c < NCORES; c++) begin : g_core
            assign fwd_m[c] = (dir_flat[(l*NCORES+c)*3 +: 3] == 3'd5);
            assign own_m[c] = (dir_flat[(l*NCORES+c)*3 +: 3] == 3'd4);
        end
        // R3: at most one forwarder per line
        a_r3_one_forwarder: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(fwd_m) <= 1);
        // R5: at most one dirty owner per line
        a_r5_one_owner: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(own_m) <= 1);
    end
endmodule

bind dir_ctrl dir_ctrl_chk #(
    .NCORES (NCORES),
    .NLINES (NLINES),
    .CW     (CW),
    .LW     (LW)
) u_dir_ctrl_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_line     (req_line),
    .snp_valid    (snp_valid),
    .snp_cmd      (snp_cmd),
    .snp_mask     (snp_mask),
    .snp_dest     (snp_dest),
    .mem_rd_valid (mem_rd_valid),
    .mem_wr_valid (mem_wr_valid),
    .gnt_valid    (gnt_valid),
    .gnt_state    (gnt_state),
    .dir_flat     (dir_flat),
    .pend_busy    (pend_busy),
    .pend_line    (pend_line)
);

// File: tb/tb_dir_ctrl.sv
module tb_dir_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NC = 4;
    localparam int NL = 4;
    localparam int MEM_LAT = 4;
    localparam int ACK_LAT = 2;

    // codes from the requirements
    localparam int RDS = 0, RDX = 1, EVC = 2;
    localparam int SI = 0, SS = 1, SE = 2, SM = 3, SO = 4, SF = 5;
    localparam int CFWD = 0, CINV = 1, CXFER = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_ready, req_dirty = 1'b0;
    logic [1:0] req_core = '0, req_line = '0, req_op = '0;
    logic snp_valid;
    logic [1:0] snp_cmd;
    logic [NC-1:0] snp_mask;
    logic [1:0] snp_dest, snp_line;
    logic [NC-1:0] inv_ack = '0;
    logic mem_rd_valid, mem_wr_valid, mem_rd_done = 1'b0;
    logic [1:0] mem_line;
    logic gnt_valid;
    logic [1:0] gnt_core, gnt_line;
    logic [2:0] gnt_state;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;
    int exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    dir_ctrl #(.NCORES(NC), .NLINES(NL)) dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_core(req_core),
        .req_line(req_line), .req_op(req_op), .req_dirty(req_dirty),
        .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_mask(snp_mask),
        .snp_dest(snp_dest), .snp_line(snp_line), .inv_ack(inv_ack),
        .mem_rd_valid(mem_rd_valid), .mem_wr_valid(mem_wr_valid),
        .mem_line(mem_line), .mem_rd_done(mem_rd_done),
        .gnt_valid(gnt_valid), .gnt_core(gnt_core), .gnt_line(gnt_line),
        .gnt_state(gnt_state)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int pack_gnt(input int core, input int line, input int st);
        return (core << 8) | (line << 4) | st;
    endfunction

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && gnt_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R11 unexpected grant", pack_gnt(gnt_core, gnt_line, gnt_state), -1);
            end else begin
                int e;
                int a;
                e = exp_q.pop_front();
                a = pack_gnt(gnt_core, gnt_line, gnt_state);
                chk(a == e, "R11 grant core/line/state", a, e);
            end
        end
    end

    // memory responder
    initial begin
        forever begin
            @(negedge clk);
            if (mem_rd_valid) begin
                repeat (MEM_LAT - 1) @(negedge clk);
                mem_rd_done = 1'b1;
                @(negedge clk);
                mem_rd_done = 1'b0;
            end
        end
    end

    // invalidate acknowledger: each core answers after its own delay
    initial begin
        forever begin
            @(negedge clk);
            if (snp_valid && snp_cmd == 2'(CINV)) begin
                logic [NC-1:0] m;
                m = snp_mask;
                for (int k = 0; k < NC; k++) begin
                    if (m[k]) begin
                        repeat (ACK_LAT) @(negedge clk);
                        inv_ack = NC'(1) << k;
                        @(negedge clk);
                        inv_ack = '0;
                    end
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            chk(1'b0, "watchdog", 0, 1);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    // issue a request; return at the negedge after acceptance
    task automatic issue(input int core, input int line, input int op, input bit dirty);
        @(negedge clk);
        req_core = 2'(core); req_line = 2'(line); req_op = 2'(op); req_dirty = dirty;
        req_valid = 1'b1;
        #1;
        while (!req_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        req_dirty = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    // check the snoop and memory strobes of the cycle after acceptance
    task automatic expect_out(input string tag, input bit sv, input int cmd, input int mask,
                              input int dest, input bit rd, input bit wr, input int line);
        chk(snp_valid == sv, {tag, " snp_valid"}, snp_valid, sv);
        if (sv) begin
            chk(snp_cmd == 2'(cmd), {tag, " snp_cmd"}, snp_cmd, cmd);
            chk(snp_mask == NC'(mask), {tag, " snp_mask"}, snp_mask, mask);
            chk(snp_dest == 2'(dest), {tag, " snp_dest"}, snp_dest, dest);
            chk(snp_line == 2'(line), {tag, " snp_line"}, snp_line, line);
        end
        chk(mem_rd_valid == rd, {tag, " mem_rd_valid"}, mem_rd_valid, rd);
        chk(mem_wr_valid == wr, {tag, " mem_wr_valid"}, mem_wr_valid, wr);
        if (rd || wr) chk(mem_line == 2'(line), {tag, " mem_line"}, mem_line, line);
    endtask

    task automatic step(input string tag, input int core, input int line, input int op,
                        input bit dirty, input int gst, input bit sv, input int cmd,
                        input int mask, input bit rd, input bit wr);
        exp_q.push_back(pack_gnt(core, line, gst));
        issue(core, line, op, dirty);
        expect_out(tag, sv, cmd, mask, core, rd, wr, line);
        drain();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(req_ready == 1'b1, "R1 req_ready", req_ready, 1);
        chk(gnt_valid == 1'b0, "R1 gnt_valid", gnt_valid, 0);
        chk(snp_valid == 1'b0, "R1 snp_valid", snp_valid, 0);
        chk(mem_rd_valid == 1'b0 && mem_wr_valid == 1'b0, "R1 mem strobes",
            {mem_rd_valid, mem_wr_valid}, 0);
        rst_n = 1'b1;

        // line 0 walk
        step("R2 first fill", 0, 0, RDS, 0, SE, 0, 0, 0, 1, 0);
        step("R3 from E", 1, 0, RDS, 0, SF, 1, CFWD, 4'b0001, 0, 0);
        step("R3 from F", 2, 0, RDS, 0, SF, 1, CFWD, 4'b0010, 0, 0);
        step("R11 repeat read", 2, 0, RDS, 0, SF, 0, 0, 0, 0, 0);
        step("R4 F clean evict", 2, 0, EVC, 0, SI, 0, 0, 0, 0, 0);
        step("R4 refill from mem", 3, 0, RDS, 0, SF, 0, 0, 0, 1, 0);

        // R8: invalidate, grant only after acks
        exp_q.push_back(pack_gnt(0, 0, SM));
        issue(0, 0, RDX, 0);
        expect_out("R8 inv", 1, CINV, 4'b1010, 0, 0, 0, 0);
        @(negedge clk);
        chk(gnt_valid == 1'b0, "R8 no early grant", gnt_valid, 0);
        @(negedge clk);
        chk(gnt_valid == 1'b0, "R8 no grant before last ack", gnt_valid, 0);
        drain();

        step("R5 M to O", 1, 0, RDS, 0, SS, 1, CFWD, 4'b0001, 0, 0);
        step("R5 owner supplies", 2, 0, RDS, 0, SS, 1, CFWD, 4'b0001, 0, 0);
        step("R6 owner evicts", 0, 0, EVC, 1, SI, 1, CXFER, 4'b0010, 0, 0);
        step("R6 new owner supplies", 3, 0, RDS, 0, SS, 1, CFWD, 4'b0010, 0, 0);
        step("R8 owner upgrade", 1, 0, RDX, 0, SM, 1, CINV, 4'b1100, 0, 0);
        step("R7 M evict", 1, 0, EVC, 1, SI, 0, 0, 0, 0, 1);

        // R10: stall same line, pass other line
        issue(0, 1, RDS, 0);
        expect_out("R10 fill", 0, 0, 0, 0, 1, 0, 1);
        req_core = 2'd1; req_line = 2'd1; req_op = 2'(RDS); req_valid = 1'b1;
        #1;
        chk(req_ready == 1'b0, "R10 same line stalled", req_ready, 0);
        req_core = 2'd2; req_line = 2'd2; req_op = 2'(EVC);
        #1;
        chk(req_ready == 1'b1, "R10 other line passes", req_ready, 1);
        exp_q.push_back(pack_gnt(2, 2, SI));
        exp_q.push_back(pack_gnt(0, 1, SE));
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        drain();
        step("R3 after stall", 1, 1, RDS, 0, SF, 1, CFWD, 4'b0001, 0, 0);

        // R9 and R7 owned without sharers
        step("R9 exclusive fill", 0, 3, RDX, 0, SM, 0, 0, 0, 1, 0);
        step("R5 line3 to O", 1, 3, RDS, 0, SS, 1, CFWD, 4'b0001, 0, 0);
        step("R7 sharer clean evict", 1, 3, EVC, 0, SI, 0, 0, 0, 0, 0);
        step("R7 lone owner evict", 0, 3, EVC, 0, SI, 0, 0, 0, 0, 1);

        // R7 dirty exclusive eviction
        step("R2 line2 fill", 3, 2, RDS, 0, SE, 0, 0, 0, 1, 0);
        step("R7 dirty E evict", 3, 2, EVC, 1, SI, 0, 0, 0, 0, 1);

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R11 all grants seen", exp_q.size(), 0);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule